// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital read-out side of a sampling converter. A small counter stands in for the conversion engine and holds the block busy for a programmable number of system clock cycles. When that count runs out, the block loads the result word into a static shift register and drops into sleep. It stays there, holding the result, until a host reads it.

The host drives an active-low select and a serial clock, both asynchronous to the system clock. Both are synchronised into the system clock domain and their edges are detected there. The block drives the data line through an output-enable (`sdo_oe`) and a data value (`sdo_data`), which together form a tri-state driver. A frame is `WORD_W` bits long. The first slot carries the end-of-conversion status and the following `WORD_W-1` slots carry the result, most significant bit first. A completed frame starts the next conversion, and so does a frame cut short by raising select.

Select may also be tied low for good, which gives two-wire operation. In that case the data line doubles as an end-of-conversion interrupt.

Top module: `conv_serial_out`

## Requirements
- R1: `sdo_oe` is the inverse of `cs_n` delayed by two system clock cycles. The driver is therefore released whenever the synchronised select is high.
- R2: While select is low and no frame is in progress, `sdo_data` is 1 during a conversion and 0 during sleep.
- R3: A conversion keeps `busy` high for exactly `CONV_CYCLES` clock cycles. At its end, `conv_data` is loaded into the shift register and the block enters sleep, whatever the level of select.
- R4: During sleep, changes on `conv_data` have no effect on the held result. Serial clock edges that arrive while select is high also have no effect, as does toggling select before the first serial clock rising edge. None of these starts a conversion.
- R5: A frame begins at the first serial clock rising edge seen in sleep with select low. At that point the status slot (value 0) is on `sdo_data`. After falling edge k, for k = 1 to `WORD_W-1`, `sdo_data` carries result bit `WORD_W-1-k`.
- R6: The `WORD_W`-th falling edge of a frame starts a conversion. `conv_start` pulses high for one cycle, `busy` rises in the same cycle, and `sdo_data` goes to 1.
- R7: A rising edge of select, seen after the first serial clock rising edge and before the `WORD_W`-th falling edge, aborts the frame and starts a conversion at once, with a `conv_start` pulse. `busy` never rises without `conv_start`.
- R8: Serial clock edges during a conversion are ignored. The bit position restarts at every new conversion, so the next frame again begins with the status slot.
- R9: With select held permanently low, `sdo_data` falls from 1 to 0 when a conversion completes. Back-to-back frames then read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the block leaves reset converting |
| cs_n | input | 1 | Active-low select, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| conv_data | input | WORD_W-1 | Result presented by the conversion engine |
| sdo_data | output | 1 | Value of the serial data line when driven |
| sdo_oe | output | 1 | Enable of the serial data line driver |
| busy | output | 1 | High while a conversion is in progress |
| conv_start | output | 1 | One-cycle pulse when a conversion starts |

## Verification
Every host input passes through two synchroniser flops before its edge is detected. Its effect on `busy`, `conv_start` and `sdo_data` therefore lands on the third rising edge of the system clock after the change, while `sdo_oe` follows select after two. The bench changes `sck` and `cs_n` only on falling system clock edges and waits four cycles before it samples any output, which clears both latencies with margin. Read bits are sampled at the end of each serial clock low phase, the instant a host would latch them. Conversion length is measured separately as a run of consecutive busy samples, one per cycle, and compared with `CONV_CYCLES`.

// File: rtl/conv_serial_out.sv
module conv_serial_out #(
  parameter int WORD_W      = 32,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [WORD_W-2:0] conv_data,
  output logic              sdo_data,
  output logic              sdo_oe,
  output logic              busy,
  output logic              conv_start
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_READ} state_t;

  state_t            state;
  logic [2:0]        sck_q, cs_q;
  logic [CNT_W-1:0]  conv_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
    end
  end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire cs_low   = ~cs_q[1];

  wire conv_done  = (state == ST_CONV) && (conv_cnt == '0);
  wire read_begin = (state == ST_SLEEP) && cs_low && sck_rise;
  wire read_end   = (state == ST_READ) && !cs_rise && sck_fall && (bit_cnt == BIT_LAST);
  wire read_abort = (state == ST_READ) && cs_rise;
  wire restart    = read_end || read_abort;
  wire shift_en   = (state == ST_READ) && !cs_rise && sck_fall && (bit_cnt != BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_CONV;
      conv_cnt   <= CNT_LOAD;
      bit_cnt    <= '0;
      shreg      <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= restart;
      if (restart) begin
        state    <= ST_CONV;
        conv_cnt <= CNT_LOAD;
        bit_cnt  <= '0;
      end else if (conv_done) begin
        state <= ST_SLEEP;
        shreg <= {1'b0, conv_data};
      end else if (state == ST_CONV) begin
        conv_cnt <= conv_cnt - 1'b1;
      end else if (read_begin) begin
        state   <= ST_READ;
        bit_cnt <= '0;
      end else if (shift_en) begin
        shreg   <= {shreg[WORD_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign busy     = (state == ST_CONV);
  assign sdo_oe   = cs_low;
  assign sdo_data = busy ? 1'b1 : shreg[WORD_W-1];

endmodule

// File: rtl/conv_serial_out_chk.sv
module conv_serial_out_chk #(
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo_data,
  input logic sdo_oe,
  input logic busy,
  input logic conv_start
);

  logic [1:0] age;
  int         busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age      <= '0;
      busy_run <= 0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  AST_OE_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (sdo_oe == !$past(cs_n, 2))); // R1
  AST_CONVERTING_DRIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdo_oe) |-> sdo_data); // R2
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == CONV_CYCLES)); // R3
  AST_START_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R6
  AST_NO_SILENT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_start); // R7

endmodule

bind conv_serial_out conv_serial_out_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_data(sdo_data),
  .sdo_oe(sdo_oe), .busy(busy), .conv_start(conv_start)
);

// File: tb/sim_conv_serial_out.sv
module sim_conv_serial_out;
  localparam int WORD_W = 32;
  localparam int CONV_CYCLES = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [WORD_W-2:0] conv_data = '0;
  logic sdo_data, sdo_oe, busy, conv_start;

  int checks = 0, fails = 0, starts = 0, run = 0, last_run = 0;
  bit first_run = 1'b1;

  always #5 clk = ~clk;

  conv_serial_out #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .conv_data(conv_data),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .busy(busy), .conv_start(conv_start));

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) starts++;
      if (busy) run++;
      else if (run != 0) begin
        if (!first_run) last_run = run;
        first_run = 1'b0;
        run = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic frame_bit(input logic [WORD_W-2:0] d, input int k);
    return (k == 0) ? 1'b0 : d[WORD_W-1-k];
  endfunction

  task automatic wait_sleep();
    int t = 0;
    while (busy && t < 2000) begin tick(1); t++; end
    tick(2);
  endtask

  task automatic set_cs(input logic v);
    cs_n = v;
    tick(4);
  endtask

  // full frame, select low; next conversion loads nxt
  task automatic full_read(input logic [WORD_W-2:0] held, input logic [WORD_W-2:0] nxt);
    int s0 = starts;
    check(sdo_data == frame_bit(held, 0), "R5 status slot", sdo_data, 0);
    for (int k = 1; k <= WORD_W; k++) begin
      sck = 1'b1; tick(4);
      sck = 1'b0; tick(4);
      if (k < WORD_W)
        check(sdo_data == frame_bit(held, k), "R5 data bit", sdo_data, frame_bit(held, k));
    end
    check(busy == 1'b1 && sdo_data == 1'b1, "R6 busy after last fall", busy, 1);
    check(starts == s0 + 1, "R6 start pulse", starts - s0, 1);
    conv_data = nxt;
  endtask

  task automatic abort_read(input int n, input logic [WORD_W-2:0] held, input logic [WORD_W-2:0] nxt);
    int s0 = starts;
    for (int k = 1; k <= n; k++) begin
      sck = 1'b1; tick(4);
      sck = 1'b0; tick(4);
      check(sdo_data == frame_bit(held, k), "R5 data bit before abort", sdo_data, frame_bit(held, k));
    end
    sck = 1'b1; tick(4);
    cs_n = 1'b1; tick(4);
    check(busy == 1'b1, "R7 abort starts conversion", busy, 1);
    check(starts == s0 + 1, "R7 abort start pulse", starts - s0, 1);
    conv_data = nxt;
    sck = 1'b0; tick(2);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [WORD_W-2:0] held, nxt;
    int s0;
    void'($urandom(32'h5eed_1234));
    held = 31'h2A5C_3E91;
    conv_data = held;
    tick(5);
    check(busy == 1'b1 && sdo_oe == 1'b0 && conv_start == 1'b0, "R1 reset state", {busy, sdo_oe, conv_start}, 3'b100);
    rst_n = 1'b1;
    tick(4);
    check(sdo_oe == 1'b0, "R1 released while select high", sdo_oe, 0);
    wait_sleep();
    check(busy == 1'b0, "R3 sleeps with select high", busy, 0);

    // R4: data changes, sck with select high, select toggle without sck
    s0 = starts;
    conv_data = 31'h1111_1111;
    sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    set_cs(1'b0);
    check(sdo_oe == 1'b1 && sdo_data == 1'b0, "R2 sleep status", sdo_data, 0);
    set_cs(1'b1);
    set_cs(1'b0);
    check(busy == 1'b0 && starts == s0, "R4 no start in sleep", starts - s0, 0);
    nxt = 31'h7FFF_0001;
    full_read(held, nxt);
    held = nxt;

    // R8: sck activity during conversion, status stays 1
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; tick(2); sck = 1'b0; tick(2);
      check(sdo_data == 1'b1, "R2 status during conversion", sdo_data, 1);
    end
    wait_sleep();
    check(last_run == CONV_CYCLES, "R3 conversion length", last_run, CONV_CYCLES);
    check(sdo_data == 1'b0, "R9 interrupt falls", sdo_data, 0);
    nxt = 31'h0000_7FFE;
    full_read(held, nxt);   // R8: frame restarts with status slot, R9 back to back
    held = nxt;
    wait_sleep();
    check(last_run == CONV_CYCLES, "R3 conversion length", last_run, CONV_CYCLES);

    // directed aborts at the edges of the window
    abort_read(0, held, 31'h1234_5678);
    held = 31'h1234_5678;
    set_cs(1'b0); wait_sleep();
    abort_read(WORD_W - 1, held, 31'h0F0F_0F0F);
    held = 31'h0F0F_0F0F;
    set_cs(1'b0); wait_sleep();

    for (int it = 0; it < 24; it++) begin
      int n = $urandom_range(0, WORD_W);
      nxt = (WORD_W - 1)'($urandom);
      if (n == WORD_W) full_read(held, nxt);
      else abort_read(n, held, nxt);
      held = nxt;
      if ($urandom_range(0, 1) == 1) begin
        set_cs(1'b1);
        check(sdo_oe == 1'b0, "R1 released", sdo_oe, 0);
        wait_sleep();
        set_cs(1'b0);
      end else begin
        set_cs(1'b0);
        wait_sleep();
      end
      check(busy == 1'b0 && sdo_data == 1'b0, "R2 status after conversion", sdo_data, 0);
    end
    check(last_run == CONV_CYCLES, "R3 conversion length", last_run, CONV_CYCLES);
    report();
  end
endmodule